// File: doc/BRIEF.md
# Instruction Line Request Controller

This block sits at the front of a multithreaded instruction fetch unit and handles line misses. For each fetch attempt it takes a thread number and a byte address. It rounds the address down to the start of its line and compares that line with the single line buffer the thread owns. When the buffer already holds that line, nothing is sent to memory and the attempt is reported as a hit. Otherwise the block sends one line read on a valid/ready request channel. The read carries the thread number and a rolling tag. The thread then waits for a response that carries the same thread number and tag.

The memory port may refuse a read. The refused read is then parked in a single retry slot shared by all threads, and a global "port blocked" flag goes up. While the flag is up, every new fetch attempt is refused. A retry indication from the port replays the parked read.

A squash makes a thread forget its outstanding read. If that thread owns the parked read, the parked read is dropped as well. A response that arrives for a forgotten read, or whose tag no longer matches, is discarded and counted. Each thread's fetch state is reported continuously, so the surrounding fetch logic can steer its decisions.

Top module: `iline_req_ctrl`

## Requirements
- R1: A fetch attempt is a hit when the thread's buffer is valid and its stored line address equals the fetch address with its low log2(LINE_BYTES) bits cleared. A hit raises `fetch_hit_o` and sends no memory request.
- R2: A fetch attempt that is neither a hit nor refused drives `mem_req_valid_o` in the same cycle. The request carries the line-aligned address, the thread number and the current tag. If `mem_req_ready_i` accepts it, the thread's state becomes WAIT_RSP (code 1) on the next cycle and its buffer is marked invalid.
- R3: Each new request (accepted or parked) takes the current value of a TAG_W-bit counter, and the counter then steps by one, wrapping at its width. A replayed request carries the tag it was first given.
- R4: A new request that is not accepted is parked in the shared retry slot. The blocked flag (`cache_blocked_o`) rises, and the thread enters WAIT_RETRY (code 2). While the flag is set, every fetch attempt is refused.
- R5: When `mem_retry_i` arrives while a request is parked, the parked request is driven again. If it is accepted, the owner enters WAIT_RSP, the slot empties and the flag clears. If it is not accepted, nothing changes.
- R6: When `mem_retry_i` arrives while the flag is set but the slot has been emptied by a squash, only the flag clears and no request is driven.
- R7: A response is taken only when all three hold: its thread is in WAIT_RSP, its tag equals that thread's outstanding tag, and the thread is not squashed in the same cycle. When taken, the thread's buffer becomes valid with the response data. The thread then enters BLOCKED (code 4) if its stall input is high, and ACC_DONE (code 3) otherwise.
- R8: Any other response is discarded. A discarded response pulses `rsp_drop_o` for one cycle, increments `drop_count_o` by one (wrapping), and changes no thread state.
- R9: A squash puts the thread into SQUASHING (code 5) on the next cycle, whatever its state, and forgets its outstanding request. If the thread owns the parked request, that request is dropped, and the flag stays set until a retry indication arrives.
- R10: While `irq_pending_i` is high, a fetch attempt whose address has both low two bits zero is refused. An attempt with either of those bits set proceeds normally.
- R11: A thread that is not in WAIT_RSP or WAIT_RETRY goes to BLOCKED while its stall input is high. A thread leaves BLOCKED, when its stall is low, and SQUASHING, when it is not squashed, to RUNNING (code 0). A fetch attempt from a thread that is not in RUNNING or ACC_DONE, or whose squash input is high, is refused.
- R12: After reset, every thread is RUNNING with an invalid buffer, the flag is clear, the slot is empty, and the tag counter and drop count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_i | input | 1 | Fetch attempt this cycle |
| fetch_tid_i | input | TID_W | Thread making the attempt |
| fetch_addr_i | input | ADDR_W | Byte address of the attempt |
| irq_pending_i | input | 1 | Interrupt pending, holds aligned fetches |
| squash_i | input | NT | Per-thread squash |
| stall_i | input | NT | Per-thread stall condition |
| mem_req_valid_o | output | 1 | Line read request valid |
| mem_req_ready_i | input | 1 | Memory port accepts the request |
| mem_req_addr_o | output | ADDR_W | Line-aligned read address |
| mem_req_tid_o | output | TID_W | Thread of the request |
| mem_req_tag_o | output | TAG_W | Tag of the request |
| mem_retry_i | input | 1 | Memory port can take a parked request |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_tid_i | input | TID_W | Response thread |
| mem_rsp_tag_i | input | TAG_W | Response tag |
| mem_rsp_data_i | input | DATA_W | Response line data |
| fetch_hit_o | output | 1 | Attempt hit the thread's buffer |
| fetch_refused_o | output | 1 | Attempt refused this cycle |
| thr_state_o | output | 3*NT | Per-thread state codes, thread k at bits [3k+2:3k] |
| line_valid_o | output | NT | Per-thread buffer valid |
| line_data_o | output | DATA_W*NT | Per-thread buffer data, thread k at [DATA_W*k +: DATA_W] |
| cache_blocked_o | output | 1 | Port blocked flag |
| rsp_drop_o | output | 1 | A response was discarded this cycle |
| drop_count_o | output | CNT_W | Discarded response count |

## Verification
The hardest state to reach from the ports is a flag raised with an empty slot. To get there, a request must be refused and parked, its owner must be squashed, and a retry indication must then arrive. The stimulus builds that path on purpose, and it also lands the squash and the retry in the same cycle. A stale response whose tag matches a re-issued request is equally hard to create. A long random phase works toward it: it draws response tags from the model's outstanding tag about half the time, while squashes and tag wrap-around keep old reads in flight.

// File: rtl/iline_pkg.sv
package iline_pkg;

  typedef enum logic [2:0] {
    TS_RUN        = 3'd0,
    TS_WAIT_RSP   = 3'd1,
    TS_WAIT_RETRY = 3'd2,
    TS_DONE       = 3'd3,
    TS_BLOCKED    = 3'd4,
    TS_SQUASH     = 3'd5
  } tstate_e;

  // Clear the offset bits of a byte address for a power-of-two line size.
  function automatic logic [63:0] line_base(input logic [63:0] addr,
                                            input int unsigned line_bytes);
    logic [63:0] mask;
    mask = 64'(line_bytes) - 64'd1;
    return addr & ~mask;
  endfunction

  // Interrupt hold applies only to addresses with both low bits clear.
  function automatic logic irq_holds(input logic pending, input logic [1:0] low);
    return pending && (low == 2'b00);
  endfunction

  function automatic logic may_fetch(input tstate_e s);
    return (s == TS_RUN) || (s == TS_DONE);
  endfunction

  function automatic logic is_waiting(input tstate_e s);
    return (s == TS_WAIT_RSP) || (s == TS_WAIT_RETRY);
  endfunction

endpackage

// File: rtl/iline_thread_ctx.sv
module iline_thread_ctx
  import iline_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash_i,
  input  logic              stall_i,
  input  logic              rsp_take_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              issue_i,
  input  logic              issue_acc_i,
  input  logic [ADDR_W-1:0] issue_line_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic              retry_acc_i,
  output tstate_e           state_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] line_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);

  tstate_e           st_q;
  logic              val_q;
  logic [ADDR_W-1:0] line_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TS_RUN;
      val_q  <= 1'b0;
      line_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (squash_i) begin
      st_q <= TS_SQUASH;
    end else if (rsp_take_i) begin
      val_q  <= 1'b1;
      data_q <= rsp_data_i;
      st_q   <= stall_i ? TS_BLOCKED : TS_DONE;
    end else if (issue_i) begin
      line_q <= issue_line_i;
      val_q  <= 1'b0;
      tag_q  <= issue_tag_i;
      st_q   <= issue_acc_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
    end else if (retry_acc_i) begin
      st_q <= TS_WAIT_RSP;
    end else if (!is_waiting(st_q)) begin
      if (stall_i)
        st_q <= TS_BLOCKED;
      else if (st_q == TS_BLOCKED || st_q == TS_SQUASH)
        st_q <= TS_RUN;
    end
  end

  assign state_o = st_q;
  assign valid_o = val_q;
  assign line_o  = line_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

endmodule

// File: rtl/iline_retry_slot.sv
module iline_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  parameter int TID_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_i,
  input  logic [TID_W-1:0]  park_tid_i,
  input  logic [ADDR_W-1:0] park_addr_i,
  input  logic [TAG_W-1:0]  park_tag_i,
  input  logic              owner_squash_i,
  input  logic              retry_i,
  input  logic              replay_acc_i,
  output logic              full_o,
  output logic [TID_W-1:0]  tid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              blocked_o
);

  logic              full_q, blk_q;
  logic [TID_W-1:0]  tid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      blk_q  <= 1'b0;
      tid_q  <= '0;
      addr_q <= '0;
      tag_q  <= '0;
    end else if (park_i) begin
      full_q <= 1'b1;
      blk_q  <= 1'b1;
      tid_q  <= park_tid_i;
      addr_q <= park_addr_i;
      tag_q  <= park_tag_i;
    end else if (owner_squash_i) begin
      full_q <= 1'b0;
      if (retry_i) blk_q <= 1'b0;
    end else if (replay_acc_i) begin
      full_q <= 1'b0;
      blk_q  <= 1'b0;
    end else if (retry_i && !full_q && blk_q) begin
      blk_q <= 1'b0;
    end
  end

  assign full_o    = full_q;
  assign blocked_o = blk_q;
  assign tid_o     = tid_q;
  assign addr_o    = addr_q;
  assign tag_o     = tag_q;

endmodule

// File: rtl/iline_drop_ctr.sv
module iline_drop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/iline_req_ctrl.sv
module iline_req_ctrl
  import iline_pkg::*;
#(
  parameter int NT         = 2,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int TAG_W      = 4,
  parameter int CNT_W      = 8,
  localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_req_i,
  input  logic [TID_W-1:0]     fetch_tid_i,
  input  logic [ADDR_W-1:0]    fetch_addr_i,
  input  logic                 irq_pending_i,
  input  logic [NT-1:0]        squash_i,
  input  logic [NT-1:0]        stall_i,
  output logic                 mem_req_valid_o,
  input  logic                 mem_req_ready_i,
  output logic [ADDR_W-1:0]    mem_req_addr_o,
  output logic [TID_W-1:0]     mem_req_tid_o,
  output logic [TAG_W-1:0]     mem_req_tag_o,
  input  logic                 mem_retry_i,
  input  logic                 mem_rsp_valid_i,
  input  logic [TID_W-1:0]     mem_rsp_tid_i,
  input  logic [TAG_W-1:0]     mem_rsp_tag_i,
  input  logic [DATA_W-1:0]    mem_rsp_data_i,
  output logic                 fetch_hit_o,
  output logic                 fetch_refused_o,
  output logic [3*NT-1:0]      thr_state_o,
  output logic [NT-1:0]        line_valid_o,
  output logic [DATA_W*NT-1:0] line_data_o,
  output logic                 cache_blocked_o,
  output logic                 rsp_drop_o,
  output logic [CNT_W-1:0]     drop_count_o
);

  localparam logic [TID_W:0] NT_LIM = (TID_W+1)'(NT);

  // Per-thread context
  tstate_e           st     [NT];
  logic              t_val  [NT];
  logic [ADDR_W-1:0] t_line [NT];
  logic [TAG_W-1:0]  t_tag  [NT];
  logic [DATA_W-1:0] t_data [NT];

  // Named internal events
  logic              f_tid_ok, r_tid_ok;
  logic [ADDR_W-1:0] f_aligned;
  logic              f_irq_hold, f_gate_ok;
  logic              f_blk_refuse, f_irq_refuse, f_busy;
  logic              f_hit, new_issue;
  logic              issue_acc, issue_park;
  logic              retry_send, replay_acc, owner_squash;
  logic              rsp_take, rsp_drop;
  logic              sel_fetchable, sel_valid, sel_squash;
  logic [ADDR_W-1:0] sel_line;
  logic [TAG_W-1:0]  tag_ctr;

  // Retry slot outputs
  logic              slot_full, blocked;
  logic [TID_W-1:0]  slot_tid;
  logic [ADDR_W-1:0] slot_addr;
  logic [TAG_W-1:0]  slot_tag;

  assign f_tid_ok  = ({1'b0, fetch_tid_i} < NT_LIM);
  assign r_tid_ok  = ({1'b0, mem_rsp_tid_i} < NT_LIM);
  assign f_aligned = ADDR_W'(line_base(64'(fetch_addr_i), LINE_BYTES));
  assign f_irq_hold = irq_holds(irq_pending_i, fetch_addr_i[1:0]);

  always_comb begin
    sel_fetchable = 1'b0;
    sel_valid     = 1'b0;
    sel_squash    = 1'b0;
    sel_line      = '0;
    if (f_tid_ok) begin
      sel_fetchable = may_fetch(st[fetch_tid_i]);
      sel_valid     = t_val[fetch_tid_i];
      sel_squash    = squash_i[fetch_tid_i];
      sel_line      = t_line[fetch_tid_i];
    end
  end

  // Fetch decision: refusal reasons in priority order, then hit, then issue
  always_comb begin
    f_blk_refuse = fetch_req_i && blocked;
    f_irq_refuse = fetch_req_i && !blocked && f_irq_hold;
    f_busy       = fetch_req_i && !blocked && !f_irq_hold &&
                   (!f_tid_ok || !sel_fetchable || sel_squash);
    f_gate_ok    = fetch_req_i && !f_blk_refuse && !f_irq_refuse && !f_busy;
    f_hit        = f_gate_ok && sel_valid && (sel_line == f_aligned);
    new_issue    = f_gate_ok && !f_hit;
  end

  assign fetch_hit_o     = f_hit;
  assign fetch_refused_o = f_blk_refuse || f_irq_refuse || f_busy;

  // Replay of the parked request
  assign owner_squash = slot_full && squash_i[slot_tid];
  assign retry_send   = mem_retry_i && slot_full && !squash_i[slot_tid];
  assign replay_acc   = retry_send && mem_req_ready_i;
  assign issue_acc    = new_issue && mem_req_ready_i;
  assign issue_park   = new_issue && !mem_req_ready_i;

  assign mem_req_valid_o = new_issue || retry_send;
  assign mem_req_addr_o  = retry_send ? slot_addr : f_aligned;
  assign mem_req_tid_o   = retry_send ? slot_tid  : fetch_tid_i;
  assign mem_req_tag_o   = retry_send ? slot_tag  : tag_ctr;

  // Response acceptance
  always_comb begin
    rsp_take = 1'b0;
    if (mem_rsp_valid_i && r_tid_ok)
      rsp_take = (st[mem_rsp_tid_i] == TS_WAIT_RSP) &&
                 (t_tag[mem_rsp_tid_i] == mem_rsp_tag_i) &&
                 !squash_i[mem_rsp_tid_i];
  end
  assign rsp_drop   = mem_rsp_valid_i && !rsp_take;
  assign rsp_drop_o = rsp_drop;

  // Rolling request tag
  always_ff @(posedge clk) begin
    if (!rst_n)         tag_ctr <= '0;
    else if (new_issue) tag_ctr <= tag_ctr + TAG_W'(1);
  end

  for (genvar k = 0; k < NT; k++) begin : g_thr
    logic mine_issue, mine_rsp, mine_replay;
    assign mine_issue  = new_issue  && (fetch_tid_i   == TID_W'(k));
    assign mine_rsp    = rsp_take   && (mem_rsp_tid_i == TID_W'(k));
    assign mine_replay = replay_acc && (slot_tid      == TID_W'(k));

    iline_thread_ctx #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .squash_i    (squash_i[k]),
      .stall_i     (stall_i[k]),
      .rsp_take_i  (mine_rsp),
      .rsp_data_i  (mem_rsp_data_i),
      .issue_i     (mine_issue),
      .issue_acc_i (mem_req_ready_i),
      .issue_line_i(f_aligned),
      .issue_tag_i (tag_ctr),
      .retry_acc_i (mine_replay),
      .state_o     (st[k]),
      .valid_o     (t_val[k]),
      .line_o      (t_line[k]),
      .tag_o       (t_tag[k]),
      .data_o      (t_data[k])
    );

    assign thr_state_o[3*k +: 3]           = st[k];
    assign line_valid_o[k]                 = t_val[k];
    assign line_data_o[DATA_W*k +: DATA_W] = t_data[k];
  end

  iline_retry_slot #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)
  ) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .park_i        (issue_park),
    .park_tid_i    (fetch_tid_i),
    .park_addr_i   (f_aligned),
    .park_tag_i    (tag_ctr),
    .owner_squash_i(owner_squash),
    .retry_i       (mem_retry_i),
    .replay_acc_i  (replay_acc),
    .full_o        (slot_full),
    .tid_o         (slot_tid),
    .addr_o        (slot_addr),
    .tag_o         (slot_tag),
    .blocked_o     (blocked)
  );

  assign cache_blocked_o = blocked;

  iline_drop_ctr #(.CNT_W(CNT_W)) u_drop (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (rsp_drop),
    .count_o(drop_count_o)
  );

endmodule

// File: rtl/iline_req_ctrl_chk.sv
module iline_req_ctrl_chk #(
  parameter int NT    = 2,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8,
  parameter int TID_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req_i,
  input logic [1:0]       addr_low,
  input logic             irq_pending_i,
  input logic [NT-1:0]    squash_i,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [TID_W-1:0] mem_req_tid_o,
  input logic             mem_retry_i,
  input logic             fetch_hit_o,
  input logic             fetch_refused_o,
  input logic [3*NT-1:0]  thr_state_o,
  input logic             cache_blocked_o,
  input logic             rsp_drop_o,
  input logic [CNT_W-1:0] drop_count_o,
  input logic             new_issue,
  input logic             retry_send,
  input logic             slot_full,
  input logic [TAG_W-1:0] tag_ctr
);

  // R2 R4: a new request and a replay never share the port
  p_single_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(new_issue && retry_send));

  // R1: a hit sends nothing
  p_hit_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit_o |-> !mem_req_valid_o);

  // R2: accepted new request leaves its thread waiting for a response
  p_wait_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (new_issue && mem_req_ready_i) |=>
      (thr_state_o[3*$past(mem_req_tid_o) +: 3] == 3'd1));

  // R3: tag steps by one per new request
  p_tag_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    new_issue |=> (tag_ctr == $past(tag_ctr) + TAG_W'(1)));

  // R4: parking raises the flag, a parked request keeps it up
  p_park_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (new_issue && !mem_req_ready_i) |=> (cache_blocked_o && slot_full));
  p_slot_holds_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |-> cache_blocked_o);
  p_blocked_refuses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_i && cache_blocked_o) |-> fetch_refused_o);

  // R6: retry with an emptied slot clears the flag
  p_empty_retry_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_retry_i && cache_blocked_o && !slot_full) |=> !cache_blocked_o);

  // R8: every discard is counted
  p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_drop_o |=> (drop_count_o == $past(drop_count_o) + CNT_W'(1)));

  // R10: interrupt hold on aligned addresses
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_i && irq_pending_i && addr_low == 2'b00) |-> !new_issue);

  // R9: squash lands the thread in SQUASHING
  for (genvar k = 0; k < NT; k++) begin : g_sq
    p_squash_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i[k] |=> (thr_state_o[3*k +: 3] == 3'd5));
  end

endmodule

bind iline_req_ctrl iline_req_ctrl_chk #(
  .NT(NT), .TAG_W(TAG_W), .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_req_i    (fetch_req_i),
  .addr_low       (fetch_addr_i[1:0]),
  .irq_pending_i  (irq_pending_i),
  .squash_i       (squash_i),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_tid_o  (mem_req_tid_o),
  .mem_retry_i    (mem_retry_i),
  .fetch_hit_o    (fetch_hit_o),
  .fetch_refused_o(fetch_refused_o),
  .thr_state_o    (thr_state_o),
  .cache_blocked_o(cache_blocked_o),
  .rsp_drop_o     (rsp_drop_o),
  .drop_count_o   (drop_count_o),
  .new_issue      (new_issue),
  .retry_send     (retry_send),
  .slot_full      (slot_full),
  .tag_ctr        (tag_ctr)
);

// File: tb/test_iline_req_ctrl.sv
module test_iline_req_ctrl;

  localparam int NT = 2;
  localparam int AW = 32;
  localparam int LB = 16;
  localparam int TW = 4;
  localparam int CW = 8;
  localparam int DW = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          f_req, irq, ready, retry, rsp_v;
  logic [0:0]    f_tid, rsp_tid;
  logic [AW-1:0] f_addr;
  logic [NT-1:0] sq, stl;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;

  logic          o_valid, o_hit, o_ref, o_blk, o_drop;
  logic [AW-1:0] o_addr;
  logic [0:0]    o_tid;
  logic [TW-1:0] o_tag;
  logic [3*NT-1:0] o_st;
  logic [NT-1:0]   o_lv;
  logic [DW*NT-1:0] o_data;
  logic [CW-1:0]   o_cnt;

  iline_req_ctrl i_iline_req_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_req_i(f_req), .fetch_tid_i(f_tid), .fetch_addr_i(f_addr),
    .irq_pending_i(irq), .squash_i(sq), .stall_i(stl),
    .mem_req_valid_o(o_valid), .mem_req_ready_i(ready),
    .mem_req_addr_o(o_addr), .mem_req_tid_o(o_tid), .mem_req_tag_o(o_tag),
    .mem_retry_i(retry),
    .mem_rsp_valid_i(rsp_v), .mem_rsp_tid_i(rsp_tid), .mem_rsp_tag_i(rsp_tag),
    .mem_rsp_data_i(rsp_data),
    .fetch_hit_o(o_hit), .fetch_refused_o(o_ref),
    .thr_state_o(o_st), .line_valid_o(o_lv), .line_data_o(o_data),
    .cache_blocked_o(o_blk), .rsp_drop_o(o_drop), .drop_count_o(o_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int            m_st  [NT];
  bit            m_val [NT];
  logic [AW-1:0] m_line[NT];
  int            m_tag [NT];
  logic [DW-1:0] m_dat [NT];
  int  m_ctr, m_drop;
  bit  m_full, m_blkd;
  int  m_otid, m_otag;
  logic [AW-1:0] m_oaddr;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    f_req = 0; f_tid = 0; f_addr = '0; irq = 0; ready = 1; retry = 0;
    rsp_v = 0; rsp_tid = 0; rsp_tag = '0; rsp_data = '0; sq = '0; stl = '0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_st[t] = 0; m_val[t] = 0; m_line[t] = '0; m_tag[t] = 0; m_dat[t] = '0;
    end
    m_ctr = 0; m_drop = 0; m_full = 0; m_blkd = 0; m_otid = 0; m_otag = 0;
    m_oaddr = '0;
  endtask

  // One cycle: inputs already set after a falling edge
  task automatic step();
    int ft, rt;
    logic [AW-1:0] al;
    bit e_ref, e_hit, e_iss, e_rs, take;
    int            n_st [NT];
    bit            n_val[NT];
    logic [AW-1:0] n_line[NT];
    int            n_tag[NT];
    logic [DW-1:0] n_dat[NT];
    #4;
    ft = int'(f_tid); rt = int'(rsp_tid);
    al = f_addr & ~AW'(LB - 1);
    e_ref = 0; e_hit = 0; e_iss = 0;
    if (f_req) begin
      if (m_blkd) e_ref = 1;
      else if (irq && f_addr[1:0] == 2'b00) e_ref = 1;
      else if (!(m_st[ft] == 0 || m_st[ft] == 3) || sq[ft]) e_ref = 1;
      else if (m_val[ft] && m_line[ft] == al) e_hit = 1;
      else e_iss = 1;
    end
    e_rs = retry && m_full && !sq[m_otid];
    take = rsp_v && m_st[rt] == 1 && m_tag[rt] == int'(rsp_tag) && !sq[rt];

    // Registered outputs
    for (int t = 0; t < NT; t++) begin
      chk("R11 thread state", DW'(o_st[3*t +: 3]), DW'(m_st[t]));
      chk("R7 line valid", DW'(o_lv[t]), DW'(m_val[t]));
      if (m_val[t]) chk("R7 line data", o_data[DW*t +: DW], m_dat[t]);
    end
    chk("R4 blocked flag", DW'(o_blk), DW'(m_blkd));
    chk("R8 drop count", DW'(o_cnt), DW'(m_drop));
    // Same-cycle outputs
    chk("R2 request valid", DW'(o_valid), DW'(e_iss || e_rs));
    chk("R1 hit", DW'(o_hit), DW'(e_hit));
    chk("R4 R10 R11 refused", DW'(o_ref), DW'(e_ref));
    chk("R8 drop pulse", DW'(o_drop), DW'(rsp_v && !take));
    if (e_iss) begin
      chk("R2 request addr", DW'(o_addr), DW'(al));
      chk("R2 request tid", DW'(o_tid), DW'(ft));
      chk("R3 request tag", DW'(o_tag), DW'(m_ctr));
    end else if (e_rs) begin
      chk("R5 replay addr", DW'(o_addr), DW'(m_oaddr));
      chk("R5 replay tid", DW'(o_tid), DW'(m_otid));
      chk("R3 replay tag", DW'(o_tag), DW'(m_otag));
    end

    // Next state, lowest priority first, later lines override
    for (int t = 0; t < NT; t++) begin
      n_st[t] = m_st[t]; n_val[t] = m_val[t]; n_line[t] = m_line[t];
      n_tag[t] = m_tag[t]; n_dat[t] = m_dat[t];
      if (m_st[t] != 1 && m_st[t] != 2) begin
        if (stl[t]) n_st[t] = 4;
        else if (m_st[t] == 4 || m_st[t] == 5) n_st[t] = 0;
      end
      if (e_rs && ready && m_otid == t) n_st[t] = 1;
      if (e_iss && ft == t) begin
        n_line[t] = al; n_val[t] = 0; n_tag[t] = m_ctr;
        n_st[t] = ready ? 1 : 2;
      end
      if (take && rt == t) begin
        n_val[t] = 1; n_dat[t] = rsp_data; n_st[t] = stl[t] ? 4 : 3;
      end
      if (sq[t]) n_st[t] = 5;
    end

    @(posedge clk);
    if (m_full && sq[m_otid]) begin
      m_full = 0;
      if (retry) m_blkd = 0;
    end else if (e_rs && ready) begin
      m_full = 0; m_blkd = 0;
    end else if (retry && !m_full && m_blkd) begin
      m_blkd = 0;
    end
    if (e_iss && !ready) begin
      m_full = 1; m_blkd = 1; m_otid = ft; m_oaddr = al; m_otag = m_ctr;
    end
    if (e_iss) m_ctr = (m_ctr + 1) % (1 << TW);
    if (rsp_v && !take) m_drop = (m_drop + 1) % (1 << CW);
    for (int t = 0; t < NT; t++) begin
      m_st[t] = n_st[t]; m_val[t] = n_val[t]; m_line[t] = n_line[t];
      m_tag[t] = n_tag[t]; m_dat[t] = n_dat[t];
    end
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    chk("R12 states after reset", DW'(o_st), DW'(0));
    chk("R12 valid after reset", DW'(o_lv), DW'(0));
    chk("R12 flag after reset", DW'(o_blk), DW'(0));
    chk("R12 count after reset", DW'(o_cnt), DW'(0));
    step();

    // R2 miss on thread 0, accepted
    f_req = 1; f_tid = 0; f_addr = 32'h1004; ready = 1; step();
    chk("R2 thread0 waits", DW'(o_st[2:0]), DW'(1));
    // R7 matching response
    rsp_v = 1; rsp_tid = 0; rsp_tag = 0; rsp_data = {4{32'hCAFE0001}}; step();
    chk("R7 thread0 done", DW'(o_st[2:0]), DW'(3));
    // R1 hit in same line
    f_req = 1; f_tid = 0; f_addr = 32'h100C; step();

    // R4 park on thread 1
    f_req = 1; f_tid = 1; f_addr = 32'h2008; ready = 0; step();
    chk("R4 flag set", DW'(o_blk), DW'(1));
    chk("R4 thread1 wait retry", DW'(o_st[5:3]), DW'(2));
    f_req = 1; f_tid = 0; f_addr = 32'h3000; step();          // R4 refused
    retry = 1; ready = 0; step();                            // R5 not accepted
    retry = 1; ready = 1; step();                            // R5 accepted
    chk("R5 flag cleared", DW'(o_blk), DW'(0));
    chk("R5 thread1 waits", DW'(o_st[5:3]), DW'(1));
    // R8 wrong tag then R7 right tag with stall
    rsp_v = 1; rsp_tid = 1; rsp_tag = 4'd7; step();
    chk("R8 count one", DW'(o_cnt), DW'(1));
    rsp_v = 1; rsp_tid = 1; rsp_tag = 4'd1; rsp_data = {4{32'h12345678}}; stl = 2'b10; step();
    chk("R7 stalled completion blocked", DW'(o_st[5:3]), DW'(4));
    step();                                                  // R11 back to running
    chk("R11 unstalled running", DW'(o_st[5:3]), DW'(0));

    // R9 R6 squash of slot owner then retry
    f_req = 1; f_tid = 0; f_addr = 32'h4000; ready = 0; step();
    sq = 2'b01; step();
    chk("R9 squashing", DW'(o_st[2:0]), DW'(5));
    chk("R9 flag stays", DW'(o_blk), DW'(1));
    retry = 1; step();
    chk("R6 flag cleared", DW'(o_blk), DW'(0));
    // R6 simultaneous squash and retry
    f_req = 1; f_tid = 1; f_addr = 32'h4800; ready = 0; step();
    sq = 2'b10; retry = 1; step();
    chk("R6 same-cycle clear", DW'(o_blk), DW'(0));
    step();

    // R9 stale response after squash
    f_req = 1; f_tid = 0; f_addr = 32'h5000; ready = 1; step();
    sq = 2'b01; step();
    rsp_v = 1; rsp_tid = 0; rsp_tag = 4'd4; step();
    chk("R9 stale dropped", DW'(o_lv[0]), DW'(0));
    step();

    // R10 interrupt hold
    f_req = 1; f_tid = 1; f_addr = 32'h6000; irq = 1; step();
    f_req = 1; f_tid = 1; f_addr = 32'h6002; irq = 1; step();
    chk("R10 unaligned proceeds", DW'(o_st[5:3]), DW'(1));

    // R11 stall while running, fetch refused while blocked
    stl = 2'b01; step();
    f_req = 1; f_tid = 0; f_addr = 32'h7000; stl = 2'b01; step();
    step();

    // Random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      f_req  = ($urandom % 2) == 0;
      f_tid  = 1'($urandom % NT);
      f_addr = 32'h1000 + 32'(($urandom % 4) * 16) + 32'($urandom % 16);
      irq    = ($urandom % 10) == 0;
      ready  = ($urandom % 10) < 7;
      retry  = ($urandom % 5) == 0;
      rsp_v  = ($urandom % 10) < 3;
      rsp_tid = 1'($urandom % NT);
      r = $urandom % 2;
      rsp_tag = r ? TW'(m_tag[int'(rsp_tid)]) : TW'($urandom);
      rsp_data = {$urandom, $urandom, $urandom, $urandom};
      for (int t = 0; t < NT; t++) begin
        sq[t]  = ($urandom % 20) == 0;
        stl[t] = ($urandom % 10) == 0;
      end
      step();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule